// File: doc/BRIEF.md
# Tag Memory with Built-in Comparator

This block is a small synchronous tag store for cache lookups. Each cycle it samples three chip enables, a write strobe, a data-load strobe, an address and a data word on the rising clock edge. A selected cycle either writes the data word into the array or reads the word at the address. Any read also compares that word against a data register. The data register captures the data bus only on edges where the load strobe is low. A lookup therefore works as a read whose data output is left undriven: the probe tag is loaded into the data register at the same edge, and the hit flag reports whether the stored tag equals the probe. After a miss, a fill write stores the new tag and loads it into the data register in the same cycle. Reads that follow, with the load strobe high, then report a hit against it.

A mode input chooses between two kinds of timing. In flow-through timing the data, valid flag and hit flag reflect the access decided at the most recent edge. In pipelined timing they pass through an output register and appear one edge later. The two output drive flags model pad enables. They follow their enable inputs combinationally.

The control is a small state machine. At every edge it moves to one of five cycle states, decided by the inputs sampled there: IDLE (not selected), READ (selected, no write, load strobe high), LOOKUP (selected, no write, load strobe low), WRITE (selected, write, load strobe high) and FILL (selected, write, load strobe low). Any state can move to any other. READ and LOOKUP produce valid read data and a compare result. IDLE, WRITE and FILL hold the hit flag high and the valid flag low.

Top module: `tag_cmp_ram`

## Requirements
- R1: The block is selected only when en_lo_a_n=0, en_hi_b=1 and en_lo_c_n=0. Every other combination gives an IDLE cycle: nothing is written and no read data is marked valid.
- R2: A selected cycle with write_n=0 stores din at addr on that edge. A later read of addr returns it.
- R3: A selected cycle with write_n=1 presents the word stored at addr on dout, with dout_vld=1.
- R4: The data register captures din on every edge where din_load_n=0, selected or not. It holds its value on every other edge.
- R5: For READ and LOOKUP cycles, hit is 1 exactly when the word read equals the data register as it stands after that edge.
- R6: For IDLE, WRITE and FILL cycles, hit is 1 and dout_vld is 0.
- R7: With flow_thru=1, dout, dout_vld and hit reflect the cycle sampled at the most recent rising edge.
- R8: With flow_thru=0, dout, dout_vld and hit reflect the cycle sampled one edge earlier than the most recent one.
- R9: rd_drive equals dout_vld AND NOT rd_drive_n, and hit_drive equals NOT hit_drive_n, both without a clock edge.
- R10: During and right after reset, in either mode, dout_vld is 0 and hit is 1.
- R11: A FILL cycle writes din and loads it into the data register. A following READ of that address (din_load_n=1) reports hit=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_lo_a_n | input | 1 | Chip enable, active low |
| en_hi_b | input | 1 | Chip enable, active high |
| en_lo_c_n | input | 1 | Chip enable, active low |
| write_n | input | 1 | Write strobe from the byte-write decode, active low |
| din_load_n | input | 1 | Data register load strobe, active low |
| flow_thru | input | 1 | 1 = flow-through timing, 0 = pipelined timing |
| rd_drive_n | input | 1 | Data output drive enable, active low, combinational |
| hit_drive_n | input | 1 | Hit output drive enable, active low, combinational |
| addr | input | AW | Tag array address |
| din | input | DW | Write data and probe tag |
| dout | output | DW | Read data |
| dout_vld | output | 1 | Read data valid |
| rd_drive | output | 1 | Data pads would be driven |
| hit | output | 1 | Compare result, high when deselected |
| hit_drive | output | 1 | Hit pad would be driven |

## Verification
The assertions assume that every input is at a defined logic level on each sampled edge. They also assume that a read happens only at an address that has been written since reset, because the array has no reset. They assume flow_thru stays the same across a write followed by a read-back. The stimulus writes every array entry before the first read and drives inputs only on falling edges. It changes the timing mode only between fixed sweeps. The sweeps cover every enable combination and both values of the load strobe in each timing mode.

// File: rtl/tag_cmp_ram_pkg.sv
package tag_cmp_ram_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_READ,
        CYC_LOOKUP,
        CYC_WRITE,
        CYC_FILL
    } cyc_e;
endpackage

// File: rtl/tag_cmp_ram_ctrl.sv
module tag_cmp_ram_ctrl
    import tag_cmp_ram_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          write_n,
    input  logic          din_load_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] probe_q,
    output logic          wr_go,
    output logic          rd_vld
);
    cyc_e cyc_q, cyc_d;

    // next-cycle decode
    always_comb begin
        unique casez ({sel, write_n, din_load_n})
            3'b0??:  cyc_d = CYC_IDLE;
            3'b100:  cyc_d = CYC_FILL;
            3'b101:  cyc_d = CYC_WRITE;
            3'b110:  cyc_d = CYC_LOOKUP;
            3'b111:  cyc_d = CYC_READ;
            default: cyc_d = CYC_IDLE;
        endcase
    end

    // state register and sampled address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= CYC_IDLE;
            addr_q <= '0;
        end else begin
            cyc_q  <= cyc_d;
            addr_q <= addr;
        end
    end

    // data register: follows the load strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_q <= '0;
        end else if (!din_load_n) begin
            probe_q <= din;
        end
    end

    // outputs of the state machine
    always_comb begin
        wr_go  = (cyc_d == CYC_WRITE) || (cyc_d == CYC_FILL);
        rd_vld = 1'b0;
        unique case (cyc_q)
            CYC_READ, CYC_LOOKUP:           rd_vld = 1'b1;
            CYC_IDLE, CYC_WRITE, CYC_FILL:  rd_vld = 1'b0;
            default:                        rd_vld = 1'b0;
        endcase
    end
endmodule

// File: rtl/tag_cmp_ram_array.sv
module tag_cmp_ram_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tag_cmp_ram_out.sv
module tag_cmp_ram_out #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_thru,
    input  logic          rd_vld,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] probe_q,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic          hit
);
    logic [DW-1:0] diff;
    logic          hit_now;
    logic [DW-1:0] dout_p;
    logic          vld_p;
    logic          hit_p;

    // bitwise difference, one lane per bit
    for (genvar b = 0; b < DW; b++) begin : g_lane
        assign diff[b] = rdata[b] ^ probe_q[b];
    end

    assign hit_now = rd_vld ? (diff == '0) : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_p <= '0;
            vld_p  <= 1'b0;
            hit_p  <= 1'b1;
        end else begin
            dout_p <= rdata;
            vld_p  <= rd_vld;
            hit_p  <= hit_now;
        end
    end

    assign dout     = flow_thru ? rdata   : dout_p;
    assign dout_vld = flow_thru ? rd_vld  : vld_p;
    assign hit      = flow_thru ? hit_now : hit_p;
endmodule

// File: rtl/tag_cmp_ram.sv
module tag_cmp_ram
    import tag_cmp_ram_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_lo_a_n,
    input  logic          en_hi_b,
    input  logic          en_lo_c_n,
    input  logic          write_n,
    input  logic          din_load_n,
    input  logic          flow_thru,
    input  logic          rd_drive_n,
    input  logic          hit_drive_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic          rd_drive,
    output logic          hit,
    output logic          hit_drive
);
    logic          sel;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] probe_q;
    logic          wr_go;
    logic          rd_vld;
    logic [DW-1:0] rdata;

    assign sel = !en_lo_a_n && en_hi_b && !en_lo_c_n;

    tag_cmp_ram_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .write_n    (write_n),
        .din_load_n (din_load_n),
        .addr       (addr),
        .din        (din),
        .addr_q     (addr_q),
        .probe_q    (probe_q),
        .wr_go      (wr_go),
        .rd_vld     (rd_vld)
    );

    tag_cmp_ram_array #(.AW(AW), .DW(DW)) u_array (
        .clk   (clk),
        .we    (wr_go),
        .waddr (addr),
        .wdata (din),
        .raddr (addr_q),
        .rdata (rdata)
    );

    tag_cmp_ram_out #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_thru (flow_thru),
        .rd_vld    (rd_vld),
        .rdata     (rdata),
        .probe_q   (probe_q),
        .dout      (dout),
        .dout_vld  (dout_vld),
        .hit       (hit)
    );

    assign rd_drive  = dout_vld && !rd_drive_n;
    assign hit_drive = !hit_drive_n;
endmodule

// File: rtl/tag_cmp_ram_chk.sv
module tag_cmp_ram_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_lo_a_n,
    input logic          en_hi_b,
    input logic          en_lo_c_n,
    input logic          write_n,
    input logic          din_load_n,
    input logic          flow_thru,
    input logic          rd_drive_n,
    input logic          hit_drive_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout,
    input logic          dout_vld,
    input logic          rd_drive,
    input logic          hit,
    input logic          hit_drive
);
    logic       sel_w;
    logic [1:0] run_q;

    assign sel_w = !en_lo_a_n && en_hi_b && !en_lo_c_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (run_q != 2'd3) begin
            run_q <= run_q + 2'd1;
        end
    end

    p_desel_hit_flow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q >= 2'd1 && flow_thru && !$past(sel_w)) |-> (hit && !dout_vld));

    p_desel_hit_pipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q >= 2'd2 && !flow_thru && !$past(sel_w, 2)) |-> (hit && !dout_vld));

    p_rd_drive_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive_n |-> !rd_drive);

    p_hit_drive_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_drive_n |-> !hit_drive);

    p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_w && !write_n) ##1 (sel_w && write_n && addr == $past(addr) && flow_thru)
        |=> (!flow_thru || (dout_vld && dout == $past(din, 2))));
endmodule

bind tag_cmp_ram tag_cmp_ram_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tag_cmp_ram_bench.sv
module tag_cmp_ram_bench;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_lo_a_n = 1'b1, en_hi_b = 1'b0, en_lo_c_n = 1'b1;
    logic          write_n = 1'b1, din_load_n = 1'b1, flow_thru = 1'b1;
    logic          rd_drive_n = 1'b1, hit_drive_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_vld, rd_drive, hit, hit_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] ref_probe = '0;
    logic          e1_vld = 1'b0, e2_vld = 1'b0;
    logic          e1_hit = 1'b1, e2_hit = 1'b1;
    logic [DW-1:0] e1_dout = '0, e2_dout = '0;

    always #5 clk = ~clk;

    tag_cmp_ram #(.AW(AW), .DW(DW)) u_tag_cmp_ram (
        .clk(clk), .rst_n(rst_n), .en_lo_a_n(en_lo_a_n), .en_hi_b(en_hi_b),
        .en_lo_c_n(en_lo_c_n), .write_n(write_n), .din_load_n(din_load_n),
        .flow_thru(flow_thru), .rd_drive_n(rd_drive_n), .hit_drive_n(hit_drive_n),
        .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld),
        .rd_drive(rd_drive), .hit(hit), .hit_drive(hit_drive)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) actual=%0h expected=%0h t=%0t",
                     req, flow_thru ? "R7" : "R8", act, exp, $time);
        end
    endtask

    // compare outputs against the expectation for the current mode
    task automatic check_outs(input string req);
        logic ev, eh;
        logic [DW-1:0] ed;
        ev = flow_thru ? e1_vld : e2_vld;
        eh = flow_thru ? e1_hit : e2_hit;
        ed = flow_thru ? e1_dout : e2_dout;
        chk(dout_vld === ev, {req, " R3 valid"}, 32'(dout_vld), 32'(ev));
        if (ev) chk(dout === ed, {req, " R3 data"}, 32'(dout), 32'(ed));
        chk(hit === eh, {req, ev ? " R5 hit" : " R6 hit"}, 32'(hit), 32'(eh));
        chk(rd_drive === (ev && !rd_drive_n), {req, " R9 rd_drive"},
            32'(rd_drive), 32'(ev && !rd_drive_n));
        chk(hit_drive === !hit_drive_n, {req, " R9 hit_drive"},
            32'(hit_drive), 32'(!hit_drive_n));
    endtask

    // called at a falling edge: check, drive, update the model, wait one cycle
    task automatic step(input logic sa_n, input logic sb, input logic sc_n,
                        input logic wn, input logic dn, input int a,
                        input logic [DW-1:0] d, input string req);
        logic s;
        check_outs(req);
        en_lo_a_n = sa_n; en_hi_b = sb; en_lo_c_n = sc_n;
        write_n = wn; din_load_n = dn; addr = AW'(a); din = d;
        rd_drive_n = a[0]; hit_drive_n = a[1];
        e2_vld = e1_vld; e2_hit = e1_hit; e2_dout = e1_dout;
        s = !sa_n && sb && !sc_n;
        if (!dn) ref_probe = d;
        if (!s || !wn) begin
            e1_vld = 1'b0; e1_hit = 1'b1;
            if (s) ref_mem[a] = d;
        end else begin
            e1_vld = 1'b1;
            e1_dout = ref_mem[a];
            e1_hit = (ref_mem[a] == ref_probe);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs held in reset, both modes
        flow_thru = 1'b1; #1;
        chk(dout_vld === 1'b0 && hit === 1'b1, "R10 flow", {dout_vld, hit}, 2'b01);
        flow_thru = 1'b0; #1;
        chk(dout_vld === 1'b0 && hit === 1'b1, "R10 pipe", {dout_vld, hit}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_vld === 1'b0 && hit === 1'b1, "R10 after", {dout_vld, hit}, 2'b01);
        flow_thru = 1'b1;

        // R2: fill every entry
        for (int a = 0; a < DEPTH; a++) step(0, 1, 0, 0, 1, a, pat(a), "R2");

        for (int m = 0; m < 2; m++) begin
            flow_thru = (m == 0);
            step(1, 0, 1, 1, 1, 0, '0, "R6 idle");
            step(1, 0, 1, 1, 1, 0, '0, "R6 idle");
            for (int a = 0; a < DEPTH; a++) begin
                step(0, 1, 0, 1, 0, a, pat(a), "R5 lookup hit");
                step(0, 1, 0, 1, 0, a, pat(a) ^ 8'h5A, "R5 lookup miss");
                step(0, 1, 0, 1, 1, a, 8'h00, "R4 read holds probe");
            end
            // R1: every non-selecting enable combination with a write strobe
            for (int k = 0; k < 8; k++) begin
                if (k != 3'b010) begin
                    step(k[2], k[1], k[0], 0, 1, k, 8'hEE, "R1 deselect");
                    step(0, 1, 0, 1, 1, k, 8'h00, "R1 readback");
                end
            end
            // R11: miss, fill, then hit on a plain read
            step(0, 1, 0, 1, 0, 3, (m == 0) ? 8'hC3 : 8'h3C, "R11 miss");
            step(0, 1, 0, 0, 0, 3, (m == 0) ? 8'hC3 : 8'h3C, "R11 fill");
            step(0, 1, 0, 1, 1, 3, 8'h00, "R11 read hit");
            // R4: plain write leaves the probe untouched
            step(0, 1, 0, 1, 0, 5, ref_mem[5], "R4 load");
            step(0, 1, 0, 0, 1, 6, 8'h99, "R4 write no load");
            step(0, 1, 0, 1, 1, 5, 8'h77, "R4 read hit");
            step(0, 1, 0, 1, 1, 6, 8'h00, "R2 readback");
            // R4: load while deselected still takes effect
            step(1, 1, 0, 1, 0, 0, ref_mem[7], "R4 load idle");
            step(0, 1, 0, 1, 1, 7, 8'h00, "R4 read hit");
            step(1, 0, 1, 1, 1, 0, '0, "R6 flush");
            step(1, 0, 1, 1, 1, 0, '0, "R6 flush");
        end
        check_outs("final");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule